// File: doc/BRIEF.md
# Four-Way Set-Associative Lookup Cache

This block is the lookup and replacement datapath of a small cache whose lines hold one 32-bit word. Each access presents a byte address and a read/write flag. The address selects one of 256 sets. All four ways of that set are checked against the address tag at once. A per-way valid-and-match vector drives the hit flag and a one-hot select into the data multiplexer. The cache answers in the same cycle as the request. Its state changes on the following clock edge.

On a read miss, a single-cycle memory port fetches the word, and that word is returned in the same cycle. The word is installed in the set: an empty way is used first, and only a full set evicts its least recently used way. Each set keeps a full recency ordering of its four ways. Every write goes to memory. A write that hits also updates the cached copy, and a write that misses leaves the cache untouched.

Top module: `quad_way_cache`

## Requirements
- R1: The address `reqAddr` is split into three fields. Bits 1..0 are a byte offset that lookup ignores. Bits 9..2 select the set. Bits 31..10 are the tag.
- R2: After reset every way of every set is invalid, so the first read of any address misses.
- R3: A read whose tag equals that of a valid way in the selected set raises `hit` and returns that way's stored word on `rdata`, with `memValid` low. At most one way matches.
- R4: A read miss keeps `hit` low and raises `memValid` with `memWe` low and `memAddr` equal to `reqAddr`. It returns `memRdata` on `rdata` in the same cycle and installs that word, so an immediate re-read hits.
- R5: A miss into a set that still has invalid ways fills the lowest-numbered invalid way.
- R6: A miss into a full set replaces the way that was least recently accessed among the four.
- R7: Every read hit, read fill and write hit makes the accessed way the most recent of its set. Ways that were more recent than it each move back by one place.
- R8: A write raises `memValid` and `memWe` and puts `reqAddr` and `reqWdata` on the memory port. On a hit the cached word becomes `reqWdata`.
- R9: A write miss allocates nothing, so a following read of the same word still misses.
- R10: With `reqValid` low, `hit` and `memValid` stay low and no cache state changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Access present this cycle |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 32 | Byte address of the access |
| reqWdata | input | 32 | Write data |
| hit | output | 1 | Access matched a valid way |
| rdata | output | 32 | Read result (cached word on hit, memory word on miss) |
| memValid | output | 1 | Memory access this cycle |
| memWe | output | 1 | Memory access is a write |
| memAddr | output | 32 | Memory byte address |
| memWdata | output | 32 | Memory write data |
| memRdata | input | 32 | Memory read data, valid in the same cycle as memValid |

## Verification
The assertions check on every cycle the rules that link ports within one cycle or across two adjacent cycles. These are: the quiet memory port when idle, write-through on every write, and the fetch and bypass of read data on a miss. They also check that at most one way matches, and that the next access to a just-refilled, just-written or write-missed word sees the correct outcome. Which way receives a refill, and how the recency order evolves over long sequences, can only be shown by the bench's scenarios. There, a behavioural recency list per set predicts the hit flag and data for every access. Eviction order becomes visible through which earlier addresses still hit.

// File: rtl/qwc_pkg.sv
package qwc_pkg;
  // Datapath strobes issued by the control each cycle
  typedef struct packed {
    logic fillWay;   // install memory word into selected way
    logic writeWay;  // overwrite data of selected (hit) way
    logic bypassRd;  // route memory read data to rdata
  } qwcStrobe_t;
endpackage

// File: rtl/qwc_datapath.sv
module qwc_datapath import qwc_pkg::*; #(
  parameter int AddrW   = 32,
  parameter int DataW   = 32,
  parameter int IndexW  = 8,
  parameter int OffsetW = 2,
  parameter int Ways    = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      reqValid,
  input  logic [AddrW-OffsetW-1:0]  wordAddr,
  input  logic [DataW-1:0]          reqWdata,
  input  logic [DataW-1:0]          memRdata,
  input  qwcStrobe_t                strobe,
  input  logic [Ways-1:0]           waySel,
  output logic [IndexW-1:0]         setIdx,
  output logic [Ways-1:0]           hitVec,
  output logic [Ways-1:0]           validVec,
  output logic [DataW-1:0]          rdata
);
  localparam int TagW = AddrW - IndexW - OffsetW;
  localparam int Sets = 1 << IndexW;

  logic [Ways-1:0]  validQ [Sets];
  logic [TagW-1:0]  tagQ   [Sets][Ways];
  logic [DataW-1:0] dataQ  [Sets][Ways];
  logic [TagW-1:0]  reqTag;
  logic [DataW-1:0] wayData;

  assign setIdx   = wordAddr[IndexW-1:0];
  assign reqTag   = wordAddr[AddrW-OffsetW-1 -: TagW];
  assign validVec = validQ[setIdx];

  // Parallel tag comparators, one per way
  for (genvar w = 0; w < Ways; w++) begin : g_cmp
    assign hitVec[w] = reqValid && validQ[setIdx][w] && (tagQ[setIdx][w] == reqTag);
  end

  // One-hot AND-OR way multiplexer
  always_comb begin
    wayData = '0;
    for (int w = 0; w < Ways; w++)
      if (hitVec[w]) wayData = wayData | dataQ[setIdx][w];
  end

  assign rdata = strobe.bypassRd ? memRdata : wayData;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < Sets; s++) validQ[s] <= '0;
    end else if (strobe.fillWay) begin
      validQ[setIdx] <= validQ[setIdx] | waySel;
    end
  end

  always_ff @(posedge clk) begin
    for (int w = 0; w < Ways; w++) begin
      if (waySel[w] && strobe.fillWay) begin
        tagQ[setIdx][w]  <= reqTag;
        dataQ[setIdx][w] <= memRdata;
      end else if (waySel[w] && strobe.writeWay) begin
        dataQ[setIdx][w] <= reqWdata;
      end
    end
  end
endmodule

// File: rtl/qwc_ctrl.sv
module qwc_ctrl import qwc_pkg::*; #(
  parameter int IndexW = 8,
  parameter int Ways   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [IndexW-1:0] setIdx,
  input  logic [Ways-1:0]   hitVec,
  input  logic [Ways-1:0]   validVec,
  output qwcStrobe_t        strobe,
  output logic [Ways-1:0]   waySel,
  output logic              memValid,
  output logic              memWe
);
  localparam int Sets = 1 << IndexW;
  localparam int AgeW = (Ways > 1) ? $clog2(Ways) : 1;

  // Age per way: 0 = most recent, Ways-1 = least recent
  logic [AgeW-1:0] ageQ [Sets][Ways];
  logic [Ways-1:0] victimSel;
  logic [AgeW-1:0] selAge;
  logic            anyHit;
  logic            touch;

  assign anyHit = |hitVec;

  always_comb begin
    logic found;
    found     = 1'b0;
    victimSel = '0;
    for (int w = 0; w < Ways; w++) begin
      if (!validVec[w] && !found) begin
        victimSel[w] = 1'b1;
        found        = 1'b1;
      end
    end
    if (!found) begin
      for (int w = 0; w < Ways; w++)
        if (ageQ[setIdx][w] == AgeW'(Ways - 1)) victimSel[w] = 1'b1;
    end
  end

  assign waySel = anyHit ? hitVec : victimSel;

  assign strobe.fillWay  = reqValid && !reqWrite && !anyHit;
  assign strobe.writeWay = reqValid && reqWrite && anyHit;
  assign strobe.bypassRd = reqValid && !reqWrite && !anyHit;
  assign memValid        = reqValid && (reqWrite || !anyHit);
  assign memWe           = reqValid && reqWrite;
  assign touch           = reqValid && (anyHit || !reqWrite);

  always_comb begin
    selAge = '0;
    for (int w = 0; w < Ways; w++)
      if (waySel[w]) selAge = ageQ[setIdx][w];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < Sets; s++)
        for (int w = 0; w < Ways; w++)
          ageQ[s][w] <= AgeW'(w);
    end else if (touch) begin
      for (int w = 0; w < Ways; w++) begin
        if (waySel[w])                    ageQ[setIdx][w] <= '0;
        else if (ageQ[setIdx][w] < selAge) ageQ[setIdx][w] <= ageQ[setIdx][w] + 1'b1;
      end
    end
  end
endmodule

// File: rtl/quad_way_cache.sv
module quad_way_cache import qwc_pkg::*; #(
  parameter int AddrW   = 32,
  parameter int DataW   = 32,
  parameter int IndexW  = 8,
  parameter int OffsetW = 2,
  parameter int Ways    = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reqValid,
  input  logic             reqWrite,
  input  logic [AddrW-1:0] reqAddr,
  input  logic [DataW-1:0] reqWdata,
  output logic             hit,
  output logic [DataW-1:0] rdata,
  output logic             memValid,
  output logic             memWe,
  output logic [AddrW-1:0] memAddr,
  output logic [DataW-1:0] memWdata,
  input  logic [DataW-1:0] memRdata
);
  qwcStrobe_t        strobe;
  logic [Ways-1:0]   waySel;
  logic [Ways-1:0]   hitVec;
  logic [Ways-1:0]   validVec;
  logic [IndexW-1:0] setIdx;

  qwc_datapath #(
    .AddrW(AddrW), .DataW(DataW), .IndexW(IndexW), .OffsetW(OffsetW), .Ways(Ways)
  ) u_dp (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid),
    .wordAddr(reqAddr[AddrW-1:OffsetW]), .reqWdata(reqWdata), .memRdata(memRdata),
    .strobe(strobe), .waySel(waySel), .setIdx(setIdx),
    .hitVec(hitVec), .validVec(validVec), .rdata(rdata)
  );

  qwc_ctrl #(.IndexW(IndexW), .Ways(Ways)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .reqWrite(reqWrite),
    .setIdx(setIdx), .hitVec(hitVec), .validVec(validVec),
    .strobe(strobe), .waySel(waySel), .memValid(memValid), .memWe(memWe)
  );

  assign hit      = |hitVec;
  assign memAddr  = reqAddr;
  assign memWdata = reqWdata;
endmodule

// File: rtl/qwc_checker.sv
module qwc_checker #(
  parameter int AddrW   = 32,
  parameter int DataW   = 32,
  parameter int OffsetW = 2,
  parameter int Ways    = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             reqValid,
  input logic             reqWrite,
  input logic [AddrW-1:0] reqAddr,
  input logic [DataW-1:0] reqWdata,
  input logic             hit,
  input logic [DataW-1:0] rdata,
  input logic             memValid,
  input logic             memWe,
  input logic [AddrW-1:0] memAddr,
  input logic [DataW-1:0] memWdata,
  input logic [DataW-1:0] memRdata,
  input logic [Ways-1:0]  hitVec
);
  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !reqValid |-> (!hit && !memValid));

  p_write_through_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (reqValid && reqWrite) |-> (memValid && memWe && memAddr == reqAddr && memWdata == reqWdata));

  p_miss_fetch_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (reqValid && !reqWrite && !hit) |-> (memValid && !memWe && memAddr == reqAddr && rdata == memRdata));

  p_hit_no_fetch_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (reqValid && !reqWrite && hit) |-> !memValid);

  p_single_match_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hitVec));

  p_refill_sticks_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(reqValid && !reqWrite && !hit) && reqValid && !reqWrite &&
     reqAddr[AddrW-1:OffsetW] == $past(reqAddr[AddrW-1:OffsetW]))
    |-> (hit && rdata == $past(memRdata)));

  p_write_hit_update_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(reqValid && reqWrite && hit) && reqValid && !reqWrite &&
     reqAddr[AddrW-1:OffsetW] == $past(reqAddr[AddrW-1:OffsetW]))
    |-> (hit && rdata == $past(reqWdata)));

  p_no_write_alloc_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(reqValid && reqWrite && !hit) && reqValid && !reqWrite &&
     reqAddr[AddrW-1:OffsetW] == $past(reqAddr[AddrW-1:OffsetW]))
    |-> !hit);
endmodule

bind quad_way_cache qwc_checker #(
  .AddrW(AddrW), .DataW(DataW), .OffsetW(OffsetW), .Ways(Ways)
) u_qwc_checker (
  .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .reqWrite(reqWrite),
  .reqAddr(reqAddr), .reqWdata(reqWdata), .hit(hit), .rdata(rdata),
  .memValid(memValid), .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata),
  .memRdata(memRdata), .hitVec(hitVec)
);

// File: tb/test_quad_way_cache.sv
module test_quad_way_cache;
  localparam int ClkPeriod = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        reqValid, reqWrite;
  logic [31:0] reqAddr, reqWdata;
  logic        hit;
  logic [31:0] rdata;
  logic        memValid, memWe;
  logic [31:0] memAddr, memWdata, memRdata;

  int checkCnt = 0;
  int failCnt  = 0;
  bit done     = 1'b0;

  // Behavioural reference: per-set way arrays plus a recency list (front = most recent)
  bit          refValid [256][4];
  int          refTag   [256][4];
  logic [31:0] refData  [256][4];
  int          lruQ     [256][$];
  logic [31:0] memStore [int];

  quad_way_cache i_quad_way_cache (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .hit(hit), .rdata(rdata),
    .memValid(memValid), .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata),
    .memRdata(memRdata)
  );

  always #(ClkPeriod/2) clk = ~clk;

  function automatic logic [31:0] mk(int tg, int ix, int off);
    return {tg[21:0], ix[7:0], off[1:0]};
  endfunction

  function automatic logic [31:0] memGet(logic [31:0] a);
    int key = int'(a[31:2]);
    if (memStore.exists(key)) return memStore[key];
    return {a[31:2], 2'b00} ^ 32'h5A5A_3C3C;
  endfunction

  function automatic void touch(int s, int w);
    for (int i = 0; i < lruQ[s].size(); i++)
      if (lruQ[s][i] == w) begin lruQ[s].delete(i); break; end
    lruQ[s].push_front(w);
  endfunction

  task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checkCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic idle(string tag, logic [31:0] addr);
    @(negedge clk);
    reqValid = 1'b0; reqWrite = 1'b0; reqAddr = addr; reqWdata = 32'hFFFF_FFFF;
    memRdata = memGet(addr);
    #(ClkPeriod/4);
    check(tag, "hit idle", {31'b0, hit}, 32'd0);
    check(tag, "memValid idle", {31'b0, memValid}, 32'd0);
  endtask

  task automatic access(string tag, bit wr, logic [31:0] addr, logic [31:0] wd);
    int s, t, w, v;
    bit expHit;
    logic [31:0] mv;
    @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqAddr = addr; reqWdata = wd;
    mv = memGet(addr);
    memRdata = mv;
    s = int'(addr[9:2]);
    t = int'(addr[31:10]);
    w = -1;
    for (int k = 0; k < 4; k++) if (refValid[s][k] && refTag[s][k] == t) w = k;
    expHit = (w >= 0);
    #(ClkPeriod/4);
    check(tag, "hit", {31'b0, hit}, {31'b0, expHit});
    check(tag, "memValid", {31'b0, memValid}, {31'b0, (wr || !expHit)});
    if (wr || !expHit) begin
      check(tag, "memWe", {31'b0, memWe}, {31'b0, wr});
      check(tag, "memAddr", memAddr, addr);
      if (wr) check(tag, "memWdata", memWdata, wd);
    end
    if (!wr) check(tag, "rdata", rdata, expHit ? refData[s][w] : mv);
    // advance the reference to the state after this edge
    if (wr) begin
      memStore[int'(addr[31:2])] = wd;
      if (expHit) begin refData[s][w] = wd; touch(s, w); end
    end else if (expHit) begin
      touch(s, w);
    end else begin
      v = -1;
      for (int k = 3; k >= 0; k--) if (!refValid[s][k]) v = k;
      if (v < 0) v = lruQ[s][lruQ[s].size() - 1];
      refValid[s][v] = 1'b1; refTag[s][v] = t; refData[s][v] = mv;
      touch(s, v);
    end
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", checkCnt, failCnt);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checkCnt++; failCnt++;
      $display("FAIL watchdog: actual running expected finished");
      finishRun();
    end
  end

  initial begin
    int unsigned x;
    for (int s = 0; s < 256; s++) begin
      lruQ[s] = {0, 1, 2, 3};
      for (int k = 0; k < 4; k++) refValid[s][k] = 1'b0;
    end
    rst_n = 1'b0; reqValid = 1'b0; reqWrite = 1'b0;
    reqAddr = '0; reqWdata = '0; memRdata = '0;
    repeat (3) @(posedge clk);
    #(ClkPeriod/4);
    check("R2", "hit in reset", {31'b0, hit}, 32'd0);
    check("R10", "memValid in reset", {31'b0, memValid}, 32'd0);
    @(negedge clk); rst_n = 1'b1;

    // R2/R4/R5: cold misses fill ways 0..3 of set 5
    access("R2", 1'b0, mk(100, 5, 0), 0);
    access("R5", 1'b0, mk(101, 5, 0), 0);
    access("R5", 1'b0, mk(102, 5, 0), 0);
    access("R5", 1'b0, mk(103, 5, 0), 0);
    // R3: all four resident
    for (int k = 0; k < 4; k++) access("R3", 1'b0, mk(100 + k, 5, 0), 0);
    // R1: other byte offsets hit, same tag at another index misses
    access("R1", 1'b0, mk(101, 5, 3), 0);
    access("R1", 1'b0, mk(101, 6, 0), 0);
    // R7/R6: touch 100, then two new tags evict least recent ones
    access("R7", 1'b0, mk(100, 5, 0), 0);
    access("R6", 1'b0, mk(104, 5, 0), 0);
    access("R6", 1'b0, mk(105, 5, 0), 0);
    access("R7", 1'b0, mk(100, 5, 0), 0);
    access("R6", 1'b0, mk(102, 5, 0), 0);
    idle("R10", mk(100, 5, 0));
    access("R10", 1'b0, mk(100, 5, 0), 0);
    // R8: write hit then read back
    access("R8", 1'b1, mk(100, 5, 1), 32'hDEAD_BEEF);
    access("R8", 1'b0, mk(100, 5, 0), 0);
    // R9: write miss, then read misses and returns written memory word
    access("R9", 1'b1, mk(200, 9, 0), 32'h1234_5678);
    access("R9", 1'b0, mk(200, 9, 0), 0);
    access("R4", 1'b0, mk(200, 9, 0), 0);

    // Mixed pseudo-random traffic over a few sets and tags
    x = 32'h1357_9BDF;
    for (int n = 0; n < 600; n++) begin
      int op, tg, ix;
      x = x * 1664525 + 1013904223;
      op = int'(x[31:28]);
      tg = 300 + int'(x[10:8]) % 6;
      ix = int'(x[5:4]);
      if (op < 2)      idle("R10", mk(tg, ix, int'(x[1:0])));
      else if (op < 6) access("R8", 1'b1, mk(tg, ix, int'(x[1:0])), x ^ 32'hA5A5_0F0F);
      else             access("R6", 1'b0, mk(tg, ix, int'(x[1:0])), 0);
    end

    done = 1'b1;
    finishRun();
  end
endmodule